// File: doc/BRIEF.md
# Paged Effective Address Generator

This unit turns the 20-bit address field of an instruction into a 26-bit physical word address. Memory holds 32-bit words and has no byte addressing. Translation places a 6-bit page number, taken from the status register, above a 20-bit logical address. Because every address produced carries the caller's page number, a process confined to one page cannot reach outside it.

There are four addressing modes. Direct mode uses the field as it is. Indexed mode adds the low 20 bits of an index register to the field, wrapping within the page. Indirect mode reads one word at the translated field address and uses the low 20 bits of that word as the final logical address, under the same page. Indexed-indirect mode adds the index first and then performs the pointer read.

A `start` pulse launches an operation. A pointer read holds a request until the memory answers with `mem_ready`. `done` marks the single cycle in which `pa` first shows the result, and `pa` keeps that value until the next accepted start.

Top module: `paged_ea_gen`

## Requirements
- R1: While reset is active and after it is released, `done`, `mem_req` and `busy` are 0 and `pa` is 0.
- R2: Mode 2'b00 (direct) gives `pa = {page, addr_field}` with `done` high in the cycle after the start edge, and no memory request.
- R3: Mode 2'b10 (indexed) gives `pa = {page, (addr_field + index_val[19:0]) mod 2^20}`. The sum wraps inside the page and never changes `pa[25:20]`.
- R4: Mode 2'b01 (indirect) issues exactly one read at `{page, addr_field}`. The result is `pa = {page, mem_rdata[19:0]}`, and bits 31:20 of the returned word have no effect.
- R5: Mode 2'b11 (indexed-indirect) issues one read at `{page, (addr_field + index_val[19:0]) mod 2^20}`. The returned pointer is then translated with the same page.
- R6: `mem_req` stays high with a steady `mem_addr` until an edge with `mem_ready` high. `done` is high in the next cycle, and `mem_req` is low from then on.
- R7: `done` is high for exactly one cycle per operation. The unit is idle, with `busy` low, in the cycle after `done`.
- R8: `start`, together with any change on `addr_field`, `index_val`, `page` or `mode`, is ignored while the unit is busy or signalling `done`. `pa` keeps the result of the accepted operation.
- R9: The page bits `pa[25:20]` and `mem_addr[25:20]` always equal the `page` value sampled at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation; accepted only when idle |
| mode | input | 2 | 00 direct, 01 indirect, 10 indexed, 11 indexed-indirect |
| addr_field | input | 20 | Address field of the instruction |
| index_val | input | 32 | Index register value; low 20 bits used |
| page | input | 6 | Page number from the status register |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 26 | Physical address of the pointer read |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Word returned by memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 26 | Physical address result |

## Verification
The assertions assume that memory raises `mem_ready` only while `mem_req` is high. They also assume that `mem_rdata` is valid in the same cycle as `mem_ready`. The bench's memory model follows this rule: it asserts ready for one cycle, only after it has seen the request, and it inserts zero to two wait cycles first. The bench keeps `start` high and scrambles every operand input while an operation is in flight. This stresses the check that inputs are ignored while busy, and it keeps the checker's stability properties exposed to changing inputs.

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
  parameter int LA_W = 20,
  parameter int PG_W = 6,
  parameter int DW   = 32,
  localparam int PA_W = LA_W + PG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [LA_W-1:0] addr_field,
  input  logic [DW-1:0]   index_val,
  input  logic [PG_W-1:0] page,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PA_W-1:0] pa
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} st_t;

  st_t             st;
  logic [LA_W-1:0] la;
  logic [PG_W-1:0] pg;

  wire [LA_W-1:0] sum = addr_field + index_val[LA_W-1:0];
  wire unused_hi = ^{index_val[DW-1:LA_W], mem_rdata[DW-1:LA_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      la <= '0;
      pg <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pg <= page;
          la <= mode[1] ? sum : addr_field;
          st <= mode[0] ? S_FETCH : S_DONE;
        end
        S_FETCH: if (mem_ready) begin
          la <= mem_rdata[LA_W-1:0];
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pa       = {pg, la};
  assign mem_addr = {pg, la};
  assign mem_req  = (st == S_FETCH);
  assign done     = (st == S_DONE);
  assign busy     = (st != S_IDLE);
endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int LA_W = 20,
  parameter int PG_W = 6,
  parameter int DW   = 32,
  localparam int PA_W = LA_W + PG_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_ready,
  input logic [DW-1:0]   mem_rdata,
  input logic            busy,
  input logic            done,
  input logic [PA_W-1:0] pa
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_req_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && mem_req));

  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_ready_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (done && !mem_req));

  p_pointer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (pa[LA_W-1:0] == $past(mem_rdata[LA_W-1:0])));

  p_page_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (pa[PA_W-1:LA_W] == $past(mem_addr[PA_W-1:LA_W])));
endmodule

bind paged_ea_gen paged_ea_gen_chk #(.LA_W(LA_W), .PG_W(PG_W), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done), .pa(pa)
);

// File: tb/paged_ea_gen_tb_top.sv
module paged_ea_gen_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  mode = 0;
  logic [19:0] addr_field = 0;
  logic [31:0] index_val = 0;
  logic [5:0]  page = 0;
  logic        mem_ready = 0;
  logic [31:0] mem_rdata = 0;
  logic        mem_req, busy, done;
  logic [25:0] mem_addr, pa;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  paged_ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_field(addr_field),
    .index_val(index_val), .page(page), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done), .pa(pa)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [19:0] f, input logic [19:0] ix,
                     input logic [5:0] pg, input logic [31:0] rd, input int w);
    logic [19:0] la;
    logic [25:0] exp_pa;
    string rq;
    la = m[1] ? 20'(f + ix) : f;
    rq = (m == 2'b00) ? "R2" : (m == 2'b10) ? "R3" : (m == 2'b01) ? "R4" : "R5";
    @(negedge clk);
    start = 1; mode = m; addr_field = f; page = pg;
    index_val = {12'hA5C, ix};
    @(negedge clk);
    mode = ~m; addr_field = ~f; page = ~pg; index_val = ~index_val;
    if (!m[0]) begin
      exp_pa = {pg, la};
      chk(done && !mem_req, rq, "done next cycle, no read", {done, mem_req}, 2'b10);
      chk(pa == exp_pa, rq, "pa", pa, exp_pa);
    end else begin
      chk(mem_req && !done, "R6", "request raised", {mem_req, done}, 2'b10);
      chk(mem_addr == {pg, la}, rq, "pointer read address", mem_addr, {pg, la});
      for (int k = 0; k < w; k++) begin
        @(negedge clk);
        chk(mem_req && mem_addr == {pg, la}, "R6", "request held steady", mem_addr, {pg, la});
      end
      mem_ready = 1; mem_rdata = rd;
      @(negedge clk);
      mem_ready = 0; mem_rdata = ~rd;
      exp_pa = {pg, rd[19:0]};
      chk(done && !mem_req, "R6", "done after ready", {done, mem_req}, 2'b10);
      chk(pa == exp_pa, rq, "translated pointer", pa, exp_pa);
      chk(pa[25:20] == pg, "R9", "page kept", pa[25:20], pg);
    end
    @(negedge clk);
    chk(!done && !busy, "R7", "single done pulse then idle", {done, busy}, 2'b00);
    chk(pa == exp_pa, "R8", "start while busy ignored", pa, exp_pa);
    start = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0]  pgs [4];
    logic [19:0] fls [4];
    logic [19:0] ixs [4];
    pgs = '{6'd0, 6'd1, 6'd37, 6'd63};
    fls = '{20'h00000, 20'hFFFFF, 20'h80000, 20'h12345};
    ixs = '{20'h00000, 20'h00001, 20'hFFFFF, 20'hABCDE};
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !busy && pa == 0, "R1", "in reset", {done, mem_req, busy, pa}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req && !busy && pa == 0, "R1", "after reset", {done, mem_req, busy, pa}, 0);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 4; a++)
          for (int x = 0; x < 4; x++)
            run(2'(m), fls[a], ixs[x], pgs[p],
                {12'(32'hF0F + a * 16 + x), 20'(fls[x] ^ ixs[a] ^ 20'(p))}, (a + x) % 3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule